// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block is a clocked monostable with one channel. It watches three asynchronous pins: an active-low trigger `trig_a_n`, an active-high trigger `trig_b` and an active-low `clr_n`. When it sees a qualifying edge, it raises `q` for a programmed number of clock cycles, and `q_n` is always the inverse of `q`. A down-counter provides the pulse timing, and the length is taken from `pulse_len` in the cycle the trigger is accepted. A pulse that is running cannot be stretched or restarted. The only way to act on it is to pull `clr_n` low, which ends it early.

Each pin passes through a two-stage synchroniser. Edges are found by comparing the synchronised sample with the sample from the previous cycle. A pin change therefore reaches `q` on the third rising clock edge after it happens. A rising edge on `clr_n` can also start a pulse, but only when the clear trigger is armed. Any pulse disarms it. It is re-armed once the synchronised inputs show an inhibiting level: `trig_a_n` high or `trig_b` low.

Top module: `os_oneshot`

## Requirements
- R1: While the synchronised `clr_n` is low, `q` is low and `q_n` is high, whatever the earlier state and the other pins. A falling `clr_n` pin reaches `q` on the third rising clock edge.
- R2: While `trig_a_n` is high or `trig_b` is low, no edge on the trigger pins starts a pulse.
- R3: A falling edge on `trig_a_n` while `trig_b` is high and `clr_n` is high raises `q` on the third rising clock edge after the pin change. `q` then stays high for exactly `pulse_len` cycles, with `pulse_len` sampled when the trigger is accepted.
- R4: A rising edge on `trig_b` while `trig_a_n` is low and `clr_n` is high starts a pulse with the same latency and width as R3.
- R5: While `q` is high, edges on `trig_a_n`, `trig_b` and a rising `clr_n` neither restart nor lengthen the pulse. The counter steps down by one every cycle.
- R6: `clr_n` going low during a pulse ends it early, and the pulse does not resume when `clr_n` returns high.
- R7: A rising edge on `clr_n` starts a pulse (latency and width as in R3) when the clear trigger is armed, `trig_a_n` is low and `trig_b` is high.
- R8: Any accepted trigger disarms the clear trigger. It is re-armed only after the synchronised inputs show `trig_a_n` high or `trig_b` low.
- R9: A `pulse_len` of 0 gives a pulse one cycle wide.
- R10: `q_n` equals the inverse of `q` in every cycle.
- R11: After reset, `q` is low and the clear trigger is disarmed. If the pins already sit at triggering levels when reset is released, no pulse starts, and a `clr_n` low-high cycle also starts none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | 1 | Active-low trigger pin, fires on its falling edge |
| trig_b | input | 1 | Active-high trigger pin, fires on its rising edge |
| clr_n | input | 1 | Active-low clear; a rising edge may trigger when armed |
| pulse_len | input | LEN_W | Pulse width in clock cycles (0 is treated as 1) |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Inverse of `q` |

## Verification
The assertions check, in every cycle, the properties that can be stated step by step:
- a low synchronised clear forces `q` low on the next cycle;
- an idle channel whose inputs are inhibiting stays idle;
- a running pulse counts down by exactly one per cycle;
- the pulse ends when the count reaches zero;
- every start of a pulse leaves the clear trigger disarmed.

Other behaviour is only visible over sequences of pin activity, so the bench's scenarios have to show it:
- the three-cycle latency from pin to output;
- the exact pulse width;
- that edges applied mid-pulse are ignored;
- that the clear trigger needs an inhibiting level between two uses;
- that there is no phantom pulse after reset.

// File: rtl/os_pkg.sv
package os_pkg;

    // Pin bundle; bit 2 = trig_a_n, bit 1 = trig_b, bit 0 = clr_n.
    typedef struct packed {
        logic trig_a_n;
        logic trig_b;
        logic clr_n;
    } os_pins_t;

    localparam int PIN_CNT = 3;

    // Synchroniser reset image: triggering levels with clear low, so that
    // the first samples after reset neither arm nor fire anything.
    localparam logic [PIN_CNT-1:0] PINS_RST = 3'b010;

    // Edge polarity per pin: 1 = rising edge, 0 = falling edge.
    localparam logic [PIN_CNT-1:0] EDGE_RISE = 3'b011;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/os_edge.sv
module os_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter logic [W-1:0] RISE    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev_q, prev_d;

    always_comb begin
        prev_d = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pol
        if (RISE[i]) begin : g_rise
            assign hit[i] = cur[i] & ~prev_q[i];
        end else begin : g_fall
            assign hit[i] = ~cur[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/os_ctrl.sv
module os_ctrl #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_lvl,
    input  logic             b_lvl,
    input  logic             c_lvl,
    input  logic             a_fall,
    input  logic             b_rise,
    input  logic             c_rise,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             q,
    output logic             armed,
    output logic [LEN_W-1:0] run_cnt
);

    typedef struct packed {
        logic             q;
        logic             armed;
        logic [LEN_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_q, st_d;

    logic trig_ab, trig_c, inhibit, fire;
    logic [LEN_W-1:0] load_val;

    always_comb begin
        inhibit  = a_lvl | ~b_lvl;
        trig_ab  = ~st_q.q & c_lvl &
                   ((a_fall & b_lvl) | (b_rise & ~a_lvl));
        trig_c   = ~st_q.q & c_rise & ~a_lvl & b_lvl & st_q.armed;
        fire     = trig_ab | trig_c;
        load_val = (pulse_len == '0) ? '0 : pulse_len - 1'b1;

        st_d = st_q;
        if (!c_lvl) begin
            st_d.q   = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.q) begin
            if (st_q.cnt == '0) begin
                st_d.q = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (fire) begin
            st_d.q   = 1'b1;
            st_d.cnt = load_val;
        end

        if (fire) begin
            st_d.armed = 1'b0;
        end else if (inhibit) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{q: 1'b0, armed: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q       = st_q.q;
    assign armed   = st_q.armed;
    assign run_cnt = st_q.cnt;

endmodule

// File: rtl/os_oneshot.sv
module os_oneshot
    import os_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_a_n,
    input  logic             trig_b,
    input  logic             clr_n,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             q,
    output logic             q_n
);

    os_pins_t pins_raw, pins_s, pins_hit;
    logic     pulse_q;
    logic     armed;
    logic [LEN_W-1:0] run_cnt;

    assign pins_raw = '{trig_a_n: trig_a_n, trig_b: trig_b, clr_n: clr_n};

    os_sync #(
        .W       (PIN_CNT),
        .RST_VAL (PINS_RST)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    os_edge #(
        .W       (PIN_CNT),
        .RST_VAL (PINS_RST),
        .RISE    (EDGE_RISE)
    ) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (pins_s),
        .hit  (pins_hit)
    );

    os_ctrl #(
        .LEN_W(LEN_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_lvl    (pins_s.trig_a_n),
        .b_lvl    (pins_s.trig_b),
        .c_lvl    (pins_s.clr_n),
        .a_fall   (pins_hit.trig_a_n),
        .b_rise   (pins_hit.trig_b),
        .c_rise   (pins_hit.clr_n),
        .pulse_len(pulse_len),
        .q        (pulse_q),
        .armed    (armed),
        .run_cnt  (run_cnt)
    );

    assign q   = pulse_q;
    assign q_n = ~pulse_q;

endmodule

// File: rtl/os_oneshot_chk.sv
module os_oneshot_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             q,
    input logic             a_s,
    input logic             b_s,
    input logic             c_s,
    input logic             armed,
    input logic [LEN_W-1:0] cnt
);

    AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !c_s |=> !q); // R1

    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && (a_s || !b_s)) |=> !q); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (q && c_s && cnt != '0) |=> (q && cnt == $past(cnt) - 1'b1)); // R5

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q && cnt == '0) |=> !q); // R3

    AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> !armed); // R8

endmodule

bind os_oneshot os_oneshot_chk #(.LEN_W(LEN_W)) i_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .q    (q),
    .a_s  (pins_s.trig_a_n),
    .b_s  (pins_s.trig_b),
    .c_s  (pins_s.clr_n),
    .armed(armed),
    .cnt  (run_cnt)
);

// File: tb/test_os_oneshot.sv
module test_os_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a_n = 1'b0;
    logic             b = 1'b1;
    logic             c_n = 1'b1;
    logic [LEN_W-1:0] len = 8'd5;
    logic             q, q_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    os_oneshot #(.LEN_W(LEN_W)) i_os_oneshot (
        .clk(clk), .rst_n(rst_n), .trig_a_n(a_n), .trig_b(b), .clr_n(c_n),
        .pulse_len(len), .q(q), .q_n(q_n)
    );

    // Reference model built from the requirements: two sync stages plus a
    // previous sample, then the trigger, clear, inhibit and arming rules.
    logic [2:0] m_p1, m_p2, m_pv;
    logic       m_q, m_arm;
    int         m_left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 = 3'b010; m_p2 = 3'b010; m_pv = 3'b010;
            m_q = 1'b0; m_arm = 1'b0; m_left = 0;
        end else begin
            logic fa, rb, rc, fire;
            fa = !m_p2[2] && m_pv[2];
            rb = m_p2[1] && !m_pv[1];
            rc = m_p2[0] && !m_pv[0];
            fire = !m_q && m_p2[0] &&
                   ((fa && m_p2[1]) || (rb && !m_p2[2]) ||
                    (rc && !m_p2[2] && m_p2[1] && m_arm));
            if (!m_p2[0]) begin
                m_q = 1'b0; m_left = 0;
            end else if (m_q) begin
                if (m_left <= 1) m_q = 1'b0;
                m_left = m_left - 1;
            end else if (fire) begin
                m_q = 1'b1;
                m_left = (len == 0) ? 1 : int'(len);
            end
            if (fire) m_arm = 1'b0;
            else if (m_p2[2] || !m_p2[1]) m_arm = 1'b1;
            m_pv = m_p2; m_p2 = m_p1; m_p1 = {a_n, b, c_n};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model comparison on every falling edge: R3/R4 general and R10.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R3/R4 model q", int'(q), int'(m_q));
            chk("R10 q_n inverse", int'(q_n), int'(!q));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Trigger already driven at this negedge; expect 3-cycle latency then n highs.
    task automatic pulse_expect(input string tag, input int n);
        int cnt = 0;
        step(2);
        chk({tag, " no early rise"}, int'(q), 0);
        step(1);
        while (q && cnt < 1000) begin
            cnt++;
            step(1);
        end
        chk({tag, " pulse width"}, cnt, n);
    endtask

    function automatic bit coin(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd2024));
        // R11: pins at triggering levels through reset
        step(4);
        rst_n = 1'b1;
        step(1);
        cmp_en = 1'b1;
        chk("R11 reset q", int'(q), 0);
        chk("R11 reset q_n", int'(q_n), 1);
        step(8);
        chk("R11 no pulse after reset", int'(q), 0);
        c_n = 1'b0; step(4); c_n = 1'b1; step(6);
        chk("R11 clear not armed", int'(q), 0);

        // R2: inhibited edges
        a_n = 1'b1; b = 1'b0; step(4);
        b = 1'b1; step(6);
        chk("R2 b rise with a high", int'(q), 0);
        b = 1'b0; step(2); a_n = 1'b0; step(6);
        chk("R2 a fall with b low", int'(q), 0);

        // R3: A falling edge
        a_n = 1'b1; b = 1'b1; step(4);
        a_n = 1'b0;
        pulse_expect("R3", 5);

        // R8: clear trigger disarmed by the A trigger
        c_n = 1'b0; step(4); c_n = 1'b1; step(6);
        chk("R8 disarmed after A trigger", int'(q), 0);

        // R7: re-arm with clear low, return to trigger levels, release clear
        c_n = 1'b0; a_n = 1'b1; step(4); a_n = 1'b0; step(4);
        c_n = 1'b1;
        pulse_expect("R7", 5);

        // R8: disarmed again after the clear trigger
        c_n = 1'b0; step(4); c_n = 1'b1; step(6);
        chk("R8 disarmed after clear trigger", int'(q), 0);

        // R4: B rising edge
        len = 8'd3;
        b = 1'b0; step(4);
        b = 1'b1;
        pulse_expect("R4", 3);

        // R5: edges during the pulse are ignored
        len = 8'd8;
        a_n = 1'b1; step(4);
        a_n = 1'b0;
        step(3);
        chk("R5 pulse started", int'(q), 1);
        b = 1'b0; step(2); b = 1'b1;
        cnt = 0;
        step(1);
        while (q && cnt < 1000) begin
            cnt++;
            step(1);
        end
        chk("R5 remaining width", cnt, 5);
        step(6);
        chk("R5 no delayed retrigger", int'(q), 0);

        // R6 / R1: clear aborts a pulse and holds it low
        len = 8'd10;
        a_n = 1'b1; step(4);
        a_n = 1'b0; step(5);
        c_n = 1'b0;
        step(2);
        chk("R6 still high before latency", int'(q), 1);
        step(1);
        chk("R6 aborted", int'(q), 0);
        a_n = 1'b1; step(3); a_n = 1'b0; step(3); b = 1'b0; step(3); b = 1'b1;
        step(10);
        chk("R1 held low by clear", int'(q), 0);
        chk("R1 q_n high", int'(q_n), 1);

        // R9: zero length gives one cycle (armed by a high while clear low)
        len = 8'd0;
        c_n = 1'b1;
        pulse_expect("R9", 1);

        // Random phase, checked against the model
        for (int i = 0; i < 4000; i++) begin
            if (coin(20)) a_n = ~a_n;
            if (coin(20)) b = ~b;
            if (coin(6)) c_n = ~c_n;
            if (coin(5)) len = LEN_W'($urandom % 7);
            step(1);
        end
        step(20);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule